// File: doc/BRIEF.md
# ADC Result Capture with Compare

This block holds the digital result of a successive-approximation converter. The converter is represented by a one-cycle completion strobe and a 10-bit sample. The block keeps the accepted result in two byte-wide result registers, a high byte and a low byte, and a simple bus reads them one byte at a time. A mode input selects 10-bit or 8-bit results. An optional automatic compare tests each sample against a programmable level and keeps only the samples that meet the chosen condition. A flag tells software that a new result is waiting.

In 10-bit mode, reading the high byte first locks the pair. The state machine has two states. `ST_OPEN` accepts results. `ST_HELD` drops every completed conversion. The transition `OPEN_TO_HELD` fires on a high-byte read in 10-bit mode. The transition `HELD_TO_OPEN` fires on a low-byte read or on a change of mode. In all other cases each state stays where it is (`OPEN_STAY`, `HELD_STAY`). In 8-bit mode the block never leaves `ST_OPEN`.

The bus read data is combinational and shows the selected byte at all times. `bus_rd` marks the cycle in which a read takes effect, at the next rising clock edge. `cfg_wr` loads the compare controls and the level in one cycle.

Top module: `adc_result_hold`

## Requirements
- R1: In 10-bit mode, each accepted conversion puts sample bits 9:8 into high-byte bits 1:0, and high-byte bits 7:2 read zero. Sample bits 7:0 go into the low byte.
- R2: In 8-bit mode, the high byte reads 0x00 and the low byte receives sample bits 7:0. Sample bits 9:8 are ignored.
- R3: In 10-bit mode, a high-byte read (`bus_sel_hi`=1 with `bus_rd`=1) moves the block to `ST_HELD`. Conversions that complete in `ST_HELD` are dropped. A low-byte read returns the result from before the freeze and returns the block to `ST_OPEN`, after which conversions are accepted again.
- R4: In 8-bit mode a high-byte read does not freeze the registers. A later conversion still updates the low byte.
- R5: In the cycle after `mode_10b` changes, the high byte is cleared and any freeze is released. A conversion that completes in the cycle of the change is dropped.
- R6: With compare disabled (`cfg_cmp_en`=0), every conversion that completes in `ST_OPEN` is accepted.
- R7: With compare enabled, polarity `cfg_cmp_ge`=0 accepts a sample below the level, and polarity 1 accepts a sample equal to or above the level. In 8-bit mode only bits 7:0 of the sample and of the level are compared.
- R8: A conversion that fails the enabled compare leaves both result bytes and the flag unchanged.
- R9: `conv_flag` is set in the cycle after a conversion is accepted. It is cleared by a low-byte read (`bus_sel_hi`=0 with `bus_rd`=1). If both happen in the same cycle, the set wins.
- R10: After reset, both bytes read 0x00, `conv_flag` is 0, the block is in `ST_OPEN`, compare is disabled and the level is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle conversion-complete strobe |
| conv_data | input | 10 | Raw sample delivered with the strobe |
| mode_10b | input | 1 | 1 = 10-bit results, 0 = 8-bit results |
| cfg_wr | input | 1 | Load the compare controls and level |
| cfg_cmp_en | input | 1 | Compare enable value to load |
| cfg_cmp_ge | input | 1 | Compare polarity to load (1 = greater or equal) |
| cfg_level | input | 10 | Compare level to load |
| bus_rd | input | 1 | Read strobe for the selected byte |
| bus_sel_hi | input | 1 | Byte select: 1 = high byte, 0 = low byte |
| bus_rdata | output | 8 | Selected result byte |
| conv_flag | output | 1 | New result waiting |

## Verification
Every 10-bit sample passes through the block with compare off. This shows that the two upper bits are placed correctly and that the high byte has no stray bits. An 8-bit sweep places nonzero values in the unused sample bits and reads the high byte between conversions. This separates a correct 8-bit path from one that leaks bits 9:8 or still locks the pair.

The compare sweep covers both polarities and both modes at several levels, including the values just below, at and just above each level. It therefore catches off-by-one and inverted-polarity faults, and a comparison that uses the wrong width. Directed sequences cover the freeze with dropped conversions, the release of a freeze by a mode change, and a conversion that coincides with a low-byte read.

// File: rtl/adc_hold_pkg.sv
package adc_hold_pkg;
    typedef enum logic [0:0] {
        ST_OPEN = 1'b0,
        ST_HELD = 1'b1
    } hold_state_t;
endpackage

// File: rtl/adc_cmp_unit.sv
module adc_cmp_unit #(
    parameter int RAW_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic             mode_10b,
    input  logic             cmp_en,
    input  logic             cmp_ge,
    input  logic [RAW_W-1:0] sample,
    input  logic [RAW_W-1:0] level,
    output logic             pass
);
    localparam int PAD_W = RAW_W - BYTE_W;

    logic [RAW_W-1:0] s_eff;
    logic [RAW_W-1:0] l_eff;
    logic             hit;

    // 8-bit mode compares only the low byte of both operands
    always_comb begin
        if (mode_10b) begin
            s_eff = sample;
            l_eff = level;
        end else begin
            s_eff = {{PAD_W{1'b0}}, sample[BYTE_W-1:0]};
            l_eff = {{PAD_W{1'b0}}, level[BYTE_W-1:0]};
        end
        hit  = cmp_ge ? (s_eff >= l_eff) : (s_eff < l_eff);
        pass = !cmp_en || hit;
    end
endmodule

// File: rtl/adc_interlock_fsm.sv
module adc_interlock_fsm
    import adc_hold_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_10b,
    input  logic        mode_chg,
    input  logic        rd_hi,
    input  logic        rd_lo,
    output hold_state_t state
);
    hold_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OPEN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OPEN: if (!mode_chg && mode_10b && rd_hi) state_nx = ST_HELD;
            ST_HELD: if (mode_chg || rd_lo)              state_nx = ST_OPEN;
            default: state_nx = ST_OPEN;
        endcase
    end

    // R4: in 8-bit mode the pair never stays locked
    a_r4_no_freeze_8b: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_10b |=> state == ST_OPEN);

    // R5: a mode change always releases the lock
    a_r5_release_on_mode: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> state == ST_OPEN);
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
    parameter int RAW_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              mode_10b,
    input  logic              mode_chg,
    input  logic              rd_lo,
    input  logic [RAW_W-1:0]  sample,
    output logic [BYTE_W-1:0] lo_q,
    output logic [RAW_W-BYTE_W-1:0] hi_q,
    output logic              flag
);
    localparam int HI_W = RAW_W - BYTE_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (mode_chg) begin
            hi_q <= '0;
        end else if (accept) begin
            lo_q <= sample[BYTE_W-1:0];
            hi_q <= mode_10b ? sample[RAW_W-1:BYTE_W] : {HI_W{1'b0}};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag <= 1'b0;
        else if (accept) flag <= 1'b1;
        else if (rd_lo)  flag <= 1'b0;
    end

    // R9: a low-byte read with no new result clears the flag
    a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !accept) |=> !flag);
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold
    import adc_hold_pkg::*;
#(
    parameter int RAW_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [RAW_W-1:0]  conv_data,
    input  logic              mode_10b,
    input  logic              cfg_wr,
    input  logic              cfg_cmp_en,
    input  logic              cfg_cmp_ge,
    input  logic [RAW_W-1:0]  cfg_level,
    input  logic              bus_rd,
    input  logic              bus_sel_hi,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              conv_flag
);
    localparam int HI_W  = RAW_W - BYTE_W;
    localparam int PAD_W = BYTE_W - HI_W;

    logic             mode_q;
    logic             mode_chg;
    logic             cmp_en_q;
    logic             cmp_ge_q;
    logic [RAW_W-1:0] level_q;
    logic             cmp_pass;
    logic             accept;
    logic             rd_hi;
    logic             rd_lo;
    logic [BYTE_W-1:0] lo_q;
    logic [HI_W-1:0]  hi_q;
    hold_state_t      state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            cmp_en_q <= 1'b0;
            cmp_ge_q <= 1'b0;
            level_q  <= '0;
        end else begin
            mode_q <= mode_10b;
            if (cfg_wr) begin
                cmp_en_q <= cfg_cmp_en;
                cmp_ge_q <= cfg_cmp_ge;
                level_q  <= cfg_level;
            end
        end
    end

    always_comb begin
        mode_chg = mode_10b != mode_q;
        rd_hi    = bus_rd && bus_sel_hi;
        rd_lo    = bus_rd && !bus_sel_hi;
        accept   = conv_done && cmp_pass && !mode_chg && (state == ST_OPEN);
        bus_rdata = bus_sel_hi ? {{PAD_W{1'b0}}, hi_q} : lo_q;
    end

    adc_cmp_unit #(.RAW_W(RAW_W), .BYTE_W(BYTE_W)) u_cmp (
        .mode_10b (mode_10b),
        .cmp_en   (cmp_en_q),
        .cmp_ge   (cmp_ge_q),
        .sample   (conv_data),
        .level    (level_q),
        .pass     (cmp_pass)
    );

    adc_interlock_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_10b (mode_10b),
        .mode_chg (mode_chg),
        .rd_hi    (rd_hi),
        .rd_lo    (rd_lo),
        .state    (state)
    );

    adc_result_regs #(.RAW_W(RAW_W), .BYTE_W(BYTE_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .mode_10b (mode_10b),
        .mode_chg (mode_chg),
        .rd_lo    (rd_lo),
        .sample   (conv_data),
        .lo_q     (lo_q),
        .hi_q     (hi_q),
        .flag     (conv_flag)
    );

    // R2: once settled in 8-bit mode the high byte is zero
    a_r2_hi_zero_8b: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_10b && !mode_chg) |-> hi_q == '0);

    // R3: while locked, results do not move
    a_r3_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && !mode_chg) |=> ($stable(lo_q) && $stable(hi_q)));

    // R8: a failed compare leaves the result untouched
    a_r8_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !cmp_pass && !mode_chg) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: tb/adc_result_hold_tb.sv
module adc_result_hold_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic       mode_10b = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_cmp_en = 1'b0;
    logic       cfg_cmp_ge = 1'b0;
    logic [9:0] cfg_level = '0;
    logic       bus_rd = 1'b0;
    logic       bus_sel_hi = 1'b0;
    logic [7:0] bus_rdata;
    logic       conv_flag;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] exp_lo = '0;
    logic [7:0] exp_hi = '0;

    always #2 clk = ~clk;

    adc_result_hold dut_i (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .mode_10b(mode_10b), .cfg_wr(cfg_wr), .cfg_cmp_en(cfg_cmp_en),
        .cfg_cmp_ge(cfg_cmp_ge), .cfg_level(cfg_level), .bus_rd(bus_rd),
        .bus_sel_hi(bus_sel_hi), .bus_rdata(bus_rdata), .conv_flag(conv_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic conv(input logic [9:0] s);
        conv_done = 1'b1;
        conv_data = s;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic rd(input logic hi, output logic [7:0] v);
        bus_sel_hi = hi;
        bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        if (m != mode_10b) exp_hi = 8'h00;
        mode_10b = m;
        @(negedge clk);
    endtask

    task automatic cfg(input logic en, input logic ge, input logic [9:0] lvl);
        cfg_wr = 1'b1; cfg_cmp_en = en; cfg_cmp_ge = ge; cfg_level = lvl;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int levels [5] = '{0, 1, 'h155, 'h200, 'h3FF};
        repeat (3) @(negedge clk);
        // R10: reset state
        bus_sel_hi = 1'b1; #1 chk("R10 hi after reset", bus_rdata, 0);
        bus_sel_hi = 1'b0; #1 chk("R10 lo after reset", bus_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 flag after reset", conv_flag, 0);
        // R10: compare disabled at reset, so a first sample lands
        conv(10'h000);
        chk("R10 compare off at reset", conv_flag, 1);
        rd(1'b0, v);

        // R1, R6, R9: every 10-bit sample, compare off
        set_mode(1'b1);
        for (int s = 0; s < 1024; s++) begin
            conv(s[9:0]);
            chk("R9 flag set", conv_flag, 1);
            rd(1'b1, v); chk("R1 high byte", v, s >> 8);
            rd(1'b0, v); chk("R1/R6 low byte", v, s & 'hFF);
            chk("R9 flag cleared", conv_flag, 0);
        end

        // R3: freeze with dropped conversions
        conv(10'h2C7);
        rd(1'b1, v); chk("R3 hi read", v, 'h02);
        conv(10'h139);
        conv(10'h3EE);
        rd(1'b0, v); chk("R3 lo keeps pre-freeze", v, 'hC7);
        rd(1'b1, v); chk("R3 hi keeps pre-freeze", v, 'h02);
        rd(1'b0, v);
        conv(10'h1A4);
        rd(1'b1, v); chk("R3 hi after release", v, 'h01);
        rd(1'b0, v); chk("R3 lo after release", v, 'hA4);

        // R2, R4: 8-bit mode, upper sample bits set, no freeze
        set_mode(1'b0);
        for (int s = 0; s < 256; s++) begin
            logic [9:0] a, b;
            a = {s[1:0] ^ 2'b11, s[7:0]};
            b = {s[1:0], s[7:0] ^ 8'h5A};
            conv(a);
            rd(1'b1, v); chk("R2 hi zero in 8-bit", v, 0);
            conv(b);
            rd(1'b0, v); chk("R4 lo updates after hi read", v, b & 'hFF);
        end

        // R9: accept and low read in the same cycle
        conv(10'h011);
        conv_done = 1'b1; conv_data = 10'h022; bus_sel_hi = 1'b0; bus_rd = 1'b1;
        #1 chk("R9 same-cycle old lo", bus_rdata, 'h11);
        @(negedge clk);
        conv_done = 1'b0; bus_rd = 1'b0;
        chk("R9 set wins over clear", conv_flag, 1);
        rd(1'b0, v); chk("R9 same-cycle new lo", v, 'h22);

        // R5: mode change releases freeze, clears hi, drops coincident sample
        set_mode(1'b1);
        conv(10'h3A5);
        rd(1'b1, v); chk("R5 hi before change", v, 'h03);
        mode_10b = 1'b0; conv_done = 1'b1; conv_data = 10'h055;
        @(negedge clk);
        conv_done = 1'b0;
        bus_sel_hi = 1'b1; #1 chk("R5 hi cleared", bus_rdata, 0);
        bus_sel_hi = 1'b0; #1 chk("R5 coincident sample dropped", bus_rdata, 'hA5);
        @(negedge clk);
        rd(1'b0, v);
        conv(10'h0C3);
        rd(1'b0, v); chk("R5 released after change", v, 'hC3);
        exp_lo = 8'hC3; exp_hi = 8'h00;

        // R7, R8: compare sweep
        for (int m = 0; m < 2; m++) begin
            set_mode(m[0]);
            for (int li = 0; li < 5; li++) begin
                for (int g = 0; g < 2; g++) begin
                    cfg(1'b1, g[0], levels[li][9:0]);
                    for (int k = 0; k < 82; k++) begin
                        int s, se, le;
                        bit pass;
                        if (k < 79) s = (k * 13 + li * 3) % 1024;
                        else        s = (levels[li] + k - 80) & 'h3FF;
                        se = m ? s : ((s & 'hFF) | 'h300);
                        le = m ? levels[li] : (levels[li] & 'hFF);
                        pass = g ? ((m ? se : se & 'hFF) >= le)
                                 : ((m ? se : se & 'hFF) < le);
                        conv(se[9:0]);
                        if (pass) begin
                            exp_lo = se[7:0];
                            exp_hi = m ? {6'd0, se[9:8]} : 8'h00;
                        end
                        chk(pass ? "R7 flag on pass" : "R8 flag on miss", conv_flag, pass);
                        rd(1'b1, v); chk("R7/R8 high byte", v, exp_hi);
                        rd(1'b0, v); chk("R7/R8 low byte", v, exp_lo);
                    end
                end
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule